// File: doc/BRIEF.md
# Electrically Erasable Byte ROM Mode Model

This block is a synthesizable, clocked model of a byte-wide read-only memory that can be written in the system and erased electrically. It has no register file and no command bus. Every operation is selected by the state of a few pins: an active-low chip enable, a combined output-enable / high-voltage pin, and address bit 9. Logic cannot carry a programming voltage. For that reason, the output-enable pin and address bit 9 each arrive as a 2-bit level code. The codes are 00 for a logic low, 01 for a logic high, 10 for the 12 V level and 11 for the 14 V level.

Reads are combinational from the pins, so the model behaves as a static memory. A program or erase takes effect when chip enable rises at the end of a low pulse. The pulse is measured in clock cycles and checked against a configured window. The high-voltage level must also have been held for a configured number of cycles before chip enable falls. Any timing violation cancels the operation and sets a sticky error flag, which only a reset clears. Programming can only clear bits, because the new byte is the stored byte AND the input byte. Only a whole-array erase can set bits back to one. Reset leaves the array erased (all ones).

Address bit 9 of the array comes from the level input for that pin: a high level selects 1 and a low level selects 0. The digital value on `addr[9]` is ignored. The address width is a parameter. Its default is 10 bits, which is the smallest width that still contains the high-voltage address pin and keeps the default array small.

Top module: `eprom_mode_model`

## Requirements
- R1: With `ce_n` = 1 the outputs are off (`dout_en` = 0, `dout` = 0), whatever the two level inputs carry, and no program or erase begins (inhibit).
- R2: With `ce_n` = 0, `oe_lvl` = 00 and `a9_lvl` at 00 or 01, `dout_en` = 1 and `dout` returns the stored byte. Its address is `addr`, with bit 9 replaced by 1 when `a9_lvl` = 01 and by 0 when `a9_lvl` = 00.
- R3: With `ce_n` = 0, any pin combination not listed as a read, identifier read, program or erase leaves the outputs off. Examples are `oe_lvl` = 01, or `oe_lvl` = 11 with `a9_lvl` not 11.
- R4: When `oe_lvl` = 10 has been stable for at least SETUP_CYC cycles and `ce_n` is then held low for PROG_MIN..PROG_MAX sampled clock edges, the stored byte at the latched address becomes the old byte AND `din`. The change is visible after the edge that samples `ce_n` high again. The outputs stay off during the pulse.
- R5: Programming never turns a 0 bit into a 1; an attempt to raise bits leaves them unchanged.
- R6: When `oe_lvl` = 11 and `a9_lvl` = 11 with every other address bit 0, and the setup and a pulse of ERASE_MIN..ERASE_MAX edges are met, every byte becomes 8'hFF. If any other address bit is 1, the same pulse is an output disable and changes nothing.
- R7: With `ce_n` = 0, `oe_lvl` = 00 and `a9_lvl` = 10, `dout` returns 8'hDA when `addr[0]` = 0 and 8'h08 when `addr[0]` = 1.
- R8: A program or erase pulse whose length lies outside its window sets `proto_err` and leaves the array unchanged.
- R9: If `ce_n` falls in a program or erase setting before the high-voltage level has been stable for SETUP_CYC cycles, `proto_err` is set and the array is unchanged.
- R10: `proto_err` stays set until reset. After reset it is 0, and every byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for pulse timing and array updates |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; its low pulse starts program or erase |
| oe_lvl | input | 2 | Level code on the output-enable / high-voltage pin |
| a9_lvl | input | 2 | Level code on address pin 9 |
| addr | input | ADDR_W | Byte address (bit 9 taken from `a9_lvl`) |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, 0 when not driven |
| dout_en | output | 1 | High when the data pins would be driven |
| proto_err | output | 1 | Sticky pulse-timing violation flag |

## Verification
Random program-then-read sequences use random addresses on both halves of the bit-9 split and random data. They separate correct AND-merging from plain overwrite, and show that the bit-9 level really selects the upper half. Directed cases hold the high-voltage level with chip enable inactive, and also try an erase with a stray address bit set. Both must leave the array untouched, while a correct erase turns everything back to ones. Pulses one cycle shorter and one cycle longer than the window, and a pulse with a too-short setup, are what distinguish the timing checks from unconditional commits. Reads of both identifier bytes distinguish the identifier path from the array path.

// File: rtl/eprom_pkg.sv
// Package: shared level codes, operation kinds and identifier bytes.
// Assumes the level code on a pin is stable for the duration of a clock cycle.
package eprom_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'b00,
        LVL_HIGH = 2'b01,
        LVL_12V  = 2'b10,
        LVL_14V  = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_PROG  = 2'b01,
        OP_ERASE = 2'b10
    } op_e;

    localparam logic [7:0] MFR_CODE   = 8'hDA;
    localparam logic [7:0] DEV_CODE   = 8'h08;
    localparam int         HV_ADDR_BIT = 9;

endpackage

// File: rtl/eprom_mode_dec.sv
// Module: eprom_mode_dec
// Purely combinational decode of the pin state into a read, identifier read,
// program request or erase request. Assumes ADDR_W > HV_ADDR_BIT.
module eprom_mode_dec
    import eprom_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  logic [1:0]        a9_lvl,
    input  logic [ADDR_W-1:0] addr,
    output logic              drive,
    output logic              id_sel,
    output logic [7:0]        id_byte,
    output logic [ADDR_W-1:0] arr_addr,
    output op_e               req_op
);

    lvl_e              oe_l;
    lvl_e              a9_l;
    logic [ADDR_W-1:0] others;
    logic              others_zero;

    assign oe_l = lvl_e'(oe_lvl);
    assign a9_l = lvl_e'(a9_lvl);

    // Array address: pin 9 digital value comes from its level code.
    always_comb begin
        arr_addr              = addr;
        arr_addr[HV_ADDR_BIT] = (a9_l == LVL_HIGH);
    end

    // All address bits other than the high-voltage pin must be low for erase.
    always_comb begin
        others              = addr;
        others[HV_ADDR_BIT] = 1'b0;
        others_zero         = (others == '0);
    end

    // Identifier byte picked by address bit 0.
    assign id_byte = addr[0] ? DEV_CODE : MFR_CODE;

    // Mode table; every unlisted combination is an output disable.
    always_comb begin
        drive  = 1'b0;
        id_sel = 1'b0;
        req_op = OP_NONE;
        if (!ce_n) begin
            unique case (oe_l)
                LVL_LOW: begin
                    if (a9_l == LVL_LOW || a9_l == LVL_HIGH) begin
                        drive = 1'b1;
                    end else if (a9_l == LVL_12V) begin
                        drive  = 1'b1;
                        id_sel = 1'b1;
                    end
                end
                LVL_12V: req_op = OP_PROG;
                LVL_14V: begin
                    if (a9_l == LVL_14V && others_zero) req_op = OP_ERASE;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/eprom_pulse_ctrl.sv
// Module: eprom_pulse_ctrl
// Measures high-voltage setup and chip-enable pulse length in clock cycles,
// latches address and data on the falling edge of chip enable, and issues a
// one-cycle commit on the rising edge if the pulse is inside its window.
// Assumes PROG_MIN <= PROG_MAX, ERASE_MIN <= ERASE_MAX, all >= 1.
module eprom_pulse_ctrl
    import eprom_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SETUP_CYC = 2,
    parameter int PROG_MIN  = 4,
    parameter int PROG_MAX  = 8,
    parameter int ERASE_MIN = 10,
    parameter int ERASE_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  op_e               req_op,
    input  logic [ADDR_W-1:0] arr_addr,
    input  logic [7:0]        din,
    output logic              prog_go,
    output logic              erase_go,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              proto_err
);

    localparam int LONGEST = (ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX;
    localparam int LEN_SAT = LONGEST + 1;
    localparam int LEN_W   = $clog2(LEN_SAT + 1);
    localparam int HV_W    = $clog2(SETUP_CYC + 1) + 1;

    logic              ce_q;
    logic [1:0]        lvl_q;
    logic [HV_W-1:0]   hv_cnt;
    logic              active;
    op_e               op_q;
    logic [LEN_W-1:0]  len;
    logic              fall;
    logic              rise_end;
    logic              hv_ok;
    logic              in_window;

    assign fall     = ce_q && !ce_n;
    assign rise_end = active && ce_n;
    assign hv_ok    = (hv_cnt >= HV_W'(SETUP_CYC));

    // Pulse-length window for the operation in flight.
    always_comb begin
        if (op_q == OP_ERASE)
            in_window = (len >= LEN_W'(ERASE_MIN)) && (len <= LEN_W'(ERASE_MAX));
        else
            in_window = (len >= LEN_W'(PROG_MIN)) && (len <= LEN_W'(PROG_MAX));
    end

    assign prog_go  = rise_end && in_window && (op_q == OP_PROG);
    assign erase_go = rise_end && in_window && (op_q == OP_ERASE);

    // Count cycles the output-enable pin has held one high-voltage level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 2'b00;
            hv_cnt <= '0;
        end else begin
            lvl_q <= oe_lvl;
            if (oe_lvl != lvl_q || !oe_lvl[1])
                hv_cnt <= '0;
            else if (hv_cnt != HV_W'(SETUP_CYC))
                hv_cnt <= hv_cnt + 1'b1;
        end
    end

    // Pulse tracking, latching and the sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q      <= 1'b1;
            active    <= 1'b0;
            op_q      <= OP_NONE;
            len       <= '0;
            wr_addr   <= '0;
            wr_data   <= 8'hFF;
            proto_err <= 1'b0;
        end else begin
            ce_q <= ce_n;
            if (fall && req_op != OP_NONE) begin
                if (hv_ok) begin
                    active  <= 1'b1;
                    op_q    <= req_op;
                    len     <= LEN_W'(1);
                    wr_addr <= arr_addr;
                    wr_data <= din;
                end else begin
                    proto_err <= 1'b1;
                end
            end else if (active && !ce_n) begin
                if (len != LEN_W'(LEN_SAT)) len <= len + 1'b1;
            end else if (rise_end) begin
                active <= 1'b0;
                if (!in_window) proto_err <= 1'b1;
            end
        end
    end

    // R10: the error flag never clears outside reset.
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |=> proto_err);

    // R4: a commit only happens on the edge where chip enable has just risen.
    assert_commit_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_go || erase_go) |-> (ce_n && !ce_q));

    // R1: chip enable held high never starts a pulse.
    assert_no_pulse_when_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n && ce_q && !active) |=> !active);

endmodule

// File: rtl/eprom_array.sv
// Module: eprom_array
// Byte storage with an asynchronous read port, an AND-merge program port and
// a whole-array erase. Reset leaves every byte erased.
module eprom_array #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              prog_go,
    input  logic              erase_go,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Static read of the addressed byte.
    assign rd_data = mem[rd_addr];

    // Storage update: erase to ones, program by clearing bits only.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_go) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog_go) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    // Checker state: the word and data of the last program, and erase flag.
    logic              prog_q;
    logic              erase_q;
    logic [ADDR_W-1:0] wa_q;
    logic [7:0]        prev_word;
    logic [7:0]        wd_q;
    logic [7:0]        post_word;
    logic [7:0]        first_word;
    logic [7:0]        last_word;

    // Capture pre-write state for the assertions below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_q    <= 1'b0;
            erase_q   <= 1'b0;
            wa_q      <= '0;
            prev_word <= 8'hFF;
            wd_q      <= 8'hFF;
        end else begin
            prog_q    <= prog_go && !erase_go;
            erase_q   <= erase_go;
            wa_q      <= wr_addr;
            prev_word <= mem[wr_addr];
            wd_q      <= wr_data;
        end
    end

    assign post_word  = mem[wa_q];
    assign first_word = mem[0];
    assign last_word  = mem[DEPTH-1];

    // R5: no bit that was 0 before a program is 1 after it.
    assert_no_bit_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_q |-> ((post_word & ~prev_word) == 8'h00));

    // R4: programmed word equals old word merged with the input byte.
    assert_prog_merge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_q |-> (post_word == (prev_word & wd_q)));

    // R6: after an erase the array ends are all ones.
    assert_erase_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        erase_q |-> (first_word == 8'hFF && last_word == 8'hFF));

endmodule

// File: rtl/eprom_mode_model.sv
// Module: eprom_mode_model (top)
// Pin-level model of an electrically erasable byte ROM. Joins the mode decoder,
// pulse controller and storage array and drives the data outputs.
// Assumes level codes: 00 low, 01 high, 10 12 V, 11 14 V.
module eprom_mode_model
    import eprom_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int SETUP_CYC = 2,
    parameter int PROG_MIN  = 4,
    parameter int PROG_MAX  = 8,
    parameter int ERASE_MIN = 10,
    parameter int ERASE_MAX = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic [1:0]        oe_lvl,
    input  logic [1:0]        a9_lvl,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              proto_err
);

    logic              drive;
    logic              id_sel;
    logic [7:0]        id_byte;
    logic [ADDR_W-1:0] arr_addr;
    op_e               req_op;
    logic              prog_go;
    logic              erase_go;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        rd_data;

    eprom_mode_dec #(.ADDR_W(ADDR_W)) u_dec (
        .ce_n     (ce_n),
        .oe_lvl   (oe_lvl),
        .a9_lvl   (a9_lvl),
        .addr     (addr),
        .drive    (drive),
        .id_sel   (id_sel),
        .id_byte  (id_byte),
        .arr_addr (arr_addr),
        .req_op   (req_op)
    );

    eprom_pulse_ctrl #(
        .ADDR_W    (ADDR_W),
        .SETUP_CYC (SETUP_CYC),
        .PROG_MIN  (PROG_MIN),
        .PROG_MAX  (PROG_MAX),
        .ERASE_MIN (ERASE_MIN),
        .ERASE_MAX (ERASE_MAX)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_lvl    (oe_lvl),
        .req_op    (req_op),
        .arr_addr  (arr_addr),
        .din       (din),
        .prog_go   (prog_go),
        .erase_go  (erase_go),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .proto_err (proto_err)
    );

    eprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (arr_addr),
        .rd_data  (rd_data),
        .prog_go  (prog_go),
        .erase_go (erase_go),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    // Output mux: identifier byte, array byte, or zero when not driven.
    assign dout_en = drive;
    assign dout    = !drive ? 8'h00 : (id_sel ? id_byte : rd_data);

    // R1: chip enable high keeps the outputs off.
    assert_standby_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!dout_en && dout == 8'h00));

    // R7: identifier reads return only the two identifier codes.
    assert_id_codes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en && a9_lvl == 2'b10) |-> (dout == MFR_CODE || dout == DEV_CODE));

    // R3: a high-voltage level on the output-enable pin never drives data.
    assert_hv_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        oe_lvl[1] |-> !dout_en);

endmodule

// File: tb/tb_eprom_mode_model.sv
`timescale 1ns/1ps
module tb_eprom_mode_model;

    localparam int ADDR_W    = 10;
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SETUP_CYC = 2;
    localparam int PROG_MIN  = 4;
    localparam int PROG_MAX  = 8;
    localparam int ERASE_MIN = 10;
    localparam int ERASE_MAX = 20;
    localparam logic [1:0] L_LOW = 2'b00, L_HIGH = 2'b01, L_12 = 2'b10, L_14 = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              ce_n;
    logic [1:0]        oe_lvl;
    logic [1:0]        a9_lvl;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        din;
    logic [7:0]        dout;
    logic              dout_en;
    logic              proto_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] ref_mem [DEPTH];

    always #2.5 clk = ~clk;

    eprom_mode_model #(
        .ADDR_W(ADDR_W), .SETUP_CYC(SETUP_CYC), .PROG_MIN(PROG_MIN),
        .PROG_MAX(PROG_MAX), .ERASE_MIN(ERASE_MIN), .ERASE_MAX(ERASE_MAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_lvl(oe_lvl), .a9_lvl(a9_lvl),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .proto_err(proto_err)
    );

    function automatic logic [1:0] lvl_of(input logic [ADDR_W-1:0] a);
        return a[9] ? L_HIGH : L_LOW;
    endfunction

    function automatic logic [7:0] merge(input logic [7:0] old, input logic [7:0] d);
        return old & d;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        ce_n = 1'b1; oe_lvl = L_LOW; a9_lvl = L_LOW; addr = '0; din = 8'hFF;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b1; oe_lvl = L_LOW; a9_lvl = L_LOW; addr = '0; din = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
    endtask

    task automatic read_chk(input string req, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ce_n = 1'b0; oe_lvl = L_LOW; a9_lvl = lvl_of(a); addr = a;
        #1;
        chk(req, {7'd0, dout_en}, 8'd1);
        chk(req, dout, ref_mem[a]);
    endtask

    task automatic pulse(input logic [1:0] oe, input logic [1:0] a9,
                         input logic [ADDR_W-1:0] a, input logic [7:0] d,
                         input int setup, input int len);
        @(negedge clk);
        ce_n = 1'b1; oe_lvl = oe; a9_lvl = a9; addr = a; din = d;
        repeat (setup) @(negedge clk);
        ce_n = 1'b0;
        #1;
        chk("R4 outputs off during pulse", {7'd0, dout_en}, 8'd0);
        repeat (len) @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        oe_lvl = L_LOW; a9_lvl = L_LOW;
    endtask

    task automatic prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        pulse(L_12, lvl_of(a), a, d, SETUP_CYC + 2, PROG_MIN + 1);
        ref_mem[a] = merge(ref_mem[a], d);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a;
        logic [7:0] d;
        void'($urandom(32'd20240611));
        do_reset();

        // R10 / R1: reset state
        #1;
        chk("R10 proto_err after reset", {7'd0, proto_err}, 8'd0);
        chk("R1 standby outputs off", {7'd0, dout_en}, 8'd0);
        chk("R1 standby dout zero", dout, 8'h00);
        read_chk("R10 erased after reset", 10'h000);
        read_chk("R10 erased after reset top", 10'h3FF);

        // R3: output disable cases
        @(negedge clk); ce_n = 1'b0; oe_lvl = L_HIGH; a9_lvl = L_LOW; #1;
        chk("R3 oe high disables", {7'd0, dout_en}, 8'd0);
        @(negedge clk); oe_lvl = L_14; a9_lvl = L_LOW; #1;
        chk("R3 unlisted combo disables", {7'd0, dout_en}, 8'd0);
        @(negedge clk); ce_n = 1'b1; oe_lvl = L_LOW; #1;
        chk("R1 ce high with oe low", {7'd0, dout_en}, 8'd0);

        // R7: identifier reads
        @(negedge clk); ce_n = 1'b0; oe_lvl = L_LOW; a9_lvl = L_12; addr = 10'h000; #1;
        chk("R7 manufacturer code", dout, 8'hDA);
        @(negedge clk); addr = 10'h001; #1;
        chk("R7 device code", dout, 8'h08);
        idle();

        // R4 / R2: random programs, each verified
        for (int i = 0; i < 40; i++) begin
            a = ADDR_W'($urandom % DEPTH);
            d = 8'($urandom);
            prog(a, d);
            read_chk("R4 program verify", a);
        end
        for (int i = 0; i < 30; i++) begin
            a = ADDR_W'($urandom % DEPTH);
            read_chk("R2 random read", a);
        end

        // R5: bits cannot rise through programming
        prog(10'h155, 8'h0F);
        prog(10'h155, 8'hF0);
        read_chk("R5 no bit raise", 10'h155);
        prog(10'h155, 8'hFF);
        read_chk("R5 writing ones keeps zeros", 10'h155);
        prog(10'h2AA, 8'h3C);
        pulse(L_12, L_HIGH, 10'h2AA, 8'h00, SETUP_CYC + 2, PROG_MAX);
        ref_mem[10'h2AA] = 8'h00;
        read_chk("R4 max-length pulse commits", 10'h2AA);
        chk("R10 no error on legal pulses", {7'd0, proto_err}, 8'd0);

        // R1: inhibit with ce high under program and erase levels
        @(negedge clk); ce_n = 1'b1; oe_lvl = L_12; addr = 10'h155; din = 8'h00;
        repeat (12) @(negedge clk);
        oe_lvl = L_14; a9_lvl = L_14; addr = '0;
        repeat (25) @(negedge clk);
        idle();
        read_chk("R1 program inhibited", 10'h155);
        read_chk("R1 erase inhibited", 10'h2AA);

        // R6: erase with stray address bit does nothing
        pulse(L_14, L_14, 10'h008, 8'hFF, SETUP_CYC + 2, ERASE_MIN + 2);
        read_chk("R6 stray address bit blocks erase", 10'h2AA);
        chk("R6 no error on disabled pulse", {7'd0, proto_err}, 8'd0);

        // R6: proper erase
        pulse(L_14, L_14, 10'h000, 8'hFF, SETUP_CYC + 2, ERASE_MIN + 2);
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'hFF;
        read_chk("R6 erase restores ones", 10'h155);
        read_chk("R6 erase restores ones", 10'h2AA);
        for (int i = 0; i < 10; i++) read_chk("R6 erase random", ADDR_W'($urandom % DEPTH));

        // R8: program pulse too long
        prog(10'h0F0, 8'hA5);
        pulse(L_12, L_LOW, 10'h0F0, 8'h00, SETUP_CYC + 2, PROG_MAX + 1);
        #1;
        chk("R8 long pulse flags", {7'd0, proto_err}, 8'd1);
        read_chk("R8 long pulse no change", 10'h0F0);
        repeat (5) @(negedge clk);
        chk("R10 flag sticky", {7'd0, proto_err}, 8'd1);

        // R8: program pulse too short
        do_reset();
        prog(10'h0F0, 8'hA5);
        pulse(L_12, L_LOW, 10'h0F0, 8'h00, SETUP_CYC + 2, PROG_MIN - 1);
        #1;
        chk("R8 short pulse flags", {7'd0, proto_err}, 8'd1);
        read_chk("R8 short pulse no change", 10'h0F0);

        // R8: erase pulse too short
        do_reset();
        prog(10'h0F0, 8'h11);
        pulse(L_14, L_14, 10'h000, 8'hFF, SETUP_CYC + 2, ERASE_MIN - 1);
        #1;
        chk("R8 short erase flags", {7'd0, proto_err}, 8'd1);
        read_chk("R8 short erase no change", 10'h0F0);

        // R9: setup too short
        do_reset();
        prog(10'h00C, 8'h77);
        pulse(L_12, L_LOW, 10'h00C, 8'h00, 1, PROG_MIN + 1);
        #1;
        chk("R9 setup violation flags", {7'd0, proto_err}, 8'd1);
        read_chk("R9 setup violation no change", 10'h00C);

        do_reset();
        #1;
        chk("R10 reset clears flag", {7'd0, proto_err}, 8'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule